// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central bookkeeping for an out-of-order pipeline that has no register renaming. Instructions arrive one per cycle, in program order, from a decode stage. Each one names an operation class, an optional destination register and two source registers. The controller assigns each instruction to a functional unit of its class. It holds the instruction there until both source operands are in the register file. It then grants the read-and-execute step, and it lets the result retire into the register file once no older reader still needs the previous value.

There are five units: an integer ALU, a load unit, a store unit and two floating-point units. Each unit holds at most one instruction. Execution itself is outside the block. A unit signals completion with a one-cycle pulse, and the controller answers with a register-file write enable and address for that unit. No result is forwarded. A consumer always reads its operands from the register file, after the producing unit has written them. The controller tracks a producer tag for each register, where zero means the value is present and any other value names the unit that will write it. It also records per-unit source tags, issue and completion status, and the relative dispatch age of the occupied units.

Top module: `scoreboard_issue`

## Requirements
- R1: After reset every unit is free and no register has a pending writer, so no grant and no write enable is raised, and the first dispatch is accepted without a stall.
- R2: Class code 0 goes to unit 0 (ALU), code 1 to unit 1 (load), code 2 to unit 2 (store) and code 3 to the lowest-numbered free floating-point unit (units 3 and 4). Bit n of `issueGrant`, `rfWe` and slice n of `rfWaddr` belong to unit n.
- R3: `dispStall` is raised for a valid dispatch when no unit of its class is free, and the instruction is then not accepted.
- R4: `dispStall` is raised for a valid dispatch with `dispWrites` set whose destination register already has a pending writer.
- R5: A unit that writes back in a cycle counts as free in that same cycle, and the pending-writer mark of its destination is already cleared for a dispatch in that cycle.
- R6: An instruction is granted only when neither source register has a pending writer. The grant may come in the same cycle as the writeback of its last producer, but not earlier than the cycle after its own dispatch.
- R7: At most one grant is raised per cycle. Among the ready instructions, the one dispatched earliest wins. `issueSrcA` and `issueSrcB` carry the source registers of the granted instruction.
- R8: A completion pulse registered at a clock edge allows writeback from the next cycle onward. A writing instruction raises its unit's `rfWe` bit with its destination on `rfWaddr`. An instruction dispatched with `dispWrites` clear frees its unit with no write enable.
- R9: Writeback is held while any other occupied, not yet granted instruction has a source equal to the destination whose producer tag was zero (a pending read of the old value).
- R10: A completion pulse on a unit that is free, or that holds an instruction not yet granted, has no effect.
- R11: Several units may write back in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dispValid | input | 1 | An instruction is offered for dispatch |
| dispClass | input | 2 | Operation class: 0 ALU, 1 load, 2 store, 3 floating point |
| dispWrites | input | 1 | The instruction writes a destination register |
| dispDst | input | 4 | Destination register |
| dispSrcA | input | 4 | First source register |
| dispSrcB | input | 4 | Second source register |
| unitDone | input | 5 | Per-unit execution completion pulse |
| dispStall | output | 1 | The offered instruction is not accepted this cycle |
| issueGrant | output | 5 | One-hot grant to read operands and start execution |
| issueSrcA | output | 4 | First source register of the granted instruction |
| issueSrcB | output | 4 | Second source register of the granted instruction |
| rfWe | output | 5 | Per-unit register-file write enable |
| rfWaddr | output | 20 | Per-unit write address, unit n in bits 4n+3..4n |

## Verification
A two-iteration load, multiply, store, increment loop shows whether an increment is held at writeback by a store that has not read its operand yet, and whether the loop's second multiply stalls on its destination. A burst of three independent floating-point operations tells a structural stall apart from lowest-free unit selection. A single producer feeding two consumers of different ages shows whether the grant order follows dispatch age rather than unit number. A long random stream over eight registers, with idle gaps and stray completion pulses, mixes every hazard with same-cycle free-then-allocate and multi-unit writeback. A behavioural model compares all outputs on every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int FP_UNITS   = 2;
  localparam int FU_COUNT   = 3 + FP_UNITS;
  localparam int TAG_W      = $clog2(FU_COUNT + 1);
  localparam int UNIT_ALU   = 0;
  localparam int UNIT_LOAD  = 1;
  localparam int UNIT_STORE = 2;
  localparam int FIRST_FP   = 3;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_FP    = 2'd3
  } opClass_e;

  // control -> datapath strobes, one bit per unit
  typedef struct packed {
    logic [FU_COUNT-1:0] alloc;
    logic [FU_COUNT-1:0] issue;
    logic [FU_COUNT-1:0] wb;
  } strobe_t;

  // a producer tag becomes zero when its unit retires this cycle
  function automatic logic [TAG_W-1:0] clearTag(input logic [TAG_W-1:0] tag,
                                                input logic [FU_COUNT-1:0] retiring);
    logic [TAG_W-1:0] res;
    res = tag;
    for (int u = 0; u < FU_COUNT; u++)
      if (retiring[u] && tag == TAG_W'(u + 1)) res = '0;
    return res;
  endfunction

endpackage

// File: rtl/sb_tables.sv
module sb_tables import sb_pkg::*; #(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             strobe,
  input  logic                                dispWrites,
  input  logic [REG_W-1:0]                    dispDst,
  input  logic [REG_W-1:0]                    dispSrcA,
  input  logic [REG_W-1:0]                    dispSrcB,
  input  logic [FU_COUNT-1:0]                 unitDone,
  output logic [FU_COUNT-1:0]                 busy,
  output logic [FU_COUNT-1:0]                 issued,
  output logic [FU_COUNT-1:0]                 execDone,
  output logic [FU_COUNT-1:0]                 writes,
  output logic [FU_COUNT-1:0][REG_W-1:0]      dst,
  output logic [FU_COUNT-1:0][REG_W-1:0]      srcA,
  output logic [FU_COUNT-1:0][REG_W-1:0]      srcB,
  output logic [FU_COUNT-1:0][TAG_W-1:0]      tagA,
  output logic [FU_COUNT-1:0][TAG_W-1:0]      tagB,
  output logic [FU_COUNT-1:0][FU_COUNT-1:0]   older,
  output logic [TAG_W-1:0]                    pendTag
);

  logic [FU_COUNT-1:0]               busyQ, issuedQ, doneQ, writesQ;
  logic [FU_COUNT-1:0][REG_W-1:0]    dstQ, srcAQ, srcBQ;
  logic [FU_COUNT-1:0][TAG_W-1:0]    tagAQ, tagBQ;
  logic [FU_COUNT-1:0][FU_COUNT-1:0] olderQ;   // olderQ[j][k]: j dispatched before k
  logic [NUM_REGS-1:0][TAG_W-1:0]    regTagQ;  // pending writer per register
  logic [TAG_W-1:0]                  allocTag;

  always_comb begin
    allocTag = '0;
    for (int u = 0; u < FU_COUNT; u++)
      if (strobe.alloc[u]) allocTag = TAG_W'(u + 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= '0;
      issuedQ <= '0;
      doneQ   <= '0;
      writesQ <= '0;
      dstQ    <= '0;
      srcAQ   <= '0;
      srcBQ   <= '0;
      tagAQ   <= '0;
      tagBQ   <= '0;
      olderQ  <= '0;
      regTagQ <= '0;
    end else begin
      for (int u = 0; u < FU_COUNT; u++) begin
        if (strobe.alloc[u]) begin
          // free-then-allocate: a new occupant overrides any retire
          busyQ[u]   <= 1'b1;
          issuedQ[u] <= 1'b0;
          doneQ[u]   <= 1'b0;
          writesQ[u] <= dispWrites;
          dstQ[u]    <= dispDst;
          srcAQ[u]   <= dispSrcA;
          srcBQ[u]   <= dispSrcB;
          tagAQ[u]   <= clearTag(regTagQ[dispSrcA], strobe.wb);
          tagBQ[u]   <= clearTag(regTagQ[dispSrcB], strobe.wb);
        end else begin
          if (strobe.wb[u])    busyQ[u]   <= 1'b0;
          if (strobe.issue[u]) issuedQ[u] <= 1'b1;
          if (unitDone[u] && busyQ[u] && issuedQ[u]) doneQ[u] <= 1'b1;
          tagAQ[u] <= clearTag(tagAQ[u], strobe.wb);
          tagBQ[u] <= clearTag(tagBQ[u], strobe.wb);
        end
      end
      for (int k = 0; k < FU_COUNT; k++) begin
        if (strobe.alloc[k]) begin
          for (int j = 0; j < FU_COUNT; j++) begin
            olderQ[k][j] <= 1'b0;
            olderQ[j][k] <= (j != k) && busyQ[j] && !strobe.wb[j];
          end
        end
      end
      for (int r = 0; r < NUM_REGS; r++)
        regTagQ[r] <= clearTag(regTagQ[r], strobe.wb);
      if (|strobe.alloc && dispWrites)
        regTagQ[dispDst] <= allocTag;
    end
  end

  assign busy     = busyQ;
  assign issued   = issuedQ;
  assign execDone = doneQ;
  assign writes   = writesQ;
  assign dst      = dstQ;
  assign srcA     = srcAQ;
  assign srcB     = srcBQ;
  assign tagA     = tagAQ;
  assign tagB     = tagBQ;
  assign older    = olderQ;
  assign pendTag  = regTagQ[dispDst];

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl import sb_pkg::*; #(
  parameter int REG_W = 4
) (
  input  logic                              dispValid,
  input  logic [1:0]                        dispClass,
  input  logic                              dispWrites,
  input  logic [TAG_W-1:0]                  pendTag,
  input  logic [FU_COUNT-1:0]               busy,
  input  logic [FU_COUNT-1:0]               issued,
  input  logic [FU_COUNT-1:0]               execDone,
  input  logic [FU_COUNT-1:0]               writes,
  input  logic [FU_COUNT-1:0][REG_W-1:0]    dst,
  input  logic [FU_COUNT-1:0][REG_W-1:0]    srcA,
  input  logic [FU_COUNT-1:0][REG_W-1:0]    srcB,
  input  logic [FU_COUNT-1:0][TAG_W-1:0]    tagA,
  input  logic [FU_COUNT-1:0][TAG_W-1:0]    tagB,
  input  logic [FU_COUNT-1:0][FU_COUNT-1:0] older,
  output strobe_t                           strobe,
  output logic                              dispStall
);

  logic [FU_COUNT-1:0] warHold, wbOh, ready, pick, freeUnit, target;
  logic [TAG_W-1:0]    pendEff;
  logic                wawHaz;

  // WAR search: an unissued reader whose operand is still in the register file
  always_comb begin
    for (int u = 0; u < FU_COUNT; u++) begin
      warHold[u] = 1'b0;
      for (int v = 0; v < FU_COUNT; v++)
        if (v != u && busy[v] && !issued[v] &&
            ((srcA[v] == dst[u] && tagA[v] == '0) ||
             (srcB[v] == dst[u] && tagB[v] == '0)))
          warHold[u] = writes[u];
    end
  end

  assign wbOh = busy & execDone & ~warHold;

  // readiness sees this cycle's retirements (same-cycle RAW release)
  always_comb begin
    for (int u = 0; u < FU_COUNT; u++)
      ready[u] = busy[u] && !issued[u] &&
                 clearTag(tagA[u], wbOh) == '0 &&
                 clearTag(tagB[u], wbOh) == '0;
  end

  // oldest-first select through the age matrix
  always_comb begin
    for (int u = 0; u < FU_COUNT; u++) begin
      pick[u] = ready[u];
      for (int j = 0; j < FU_COUNT; j++)
        if (ready[j] && older[j][u]) pick[u] = 1'b0;
    end
  end

  assign freeUnit = ~busy | wbOh;

  always_comb begin
    target = '0;
    case (opClass_e'(dispClass))
      CLS_ALU:   target[UNIT_ALU]   = freeUnit[UNIT_ALU];
      CLS_LOAD:  target[UNIT_LOAD]  = freeUnit[UNIT_LOAD];
      CLS_STORE: target[UNIT_STORE] = freeUnit[UNIT_STORE];
      CLS_FP: begin
        for (int u = FU_COUNT - 1; u >= FIRST_FP; u--)
          if (freeUnit[u]) begin
            target    = '0;
            target[u] = 1'b1;
          end
      end
    endcase
  end

  assign pendEff   = clearTag(pendTag, wbOh);
  assign wawHaz    = dispWrites && pendEff != '0;
  assign dispStall = dispValid && (target == '0 || wawHaz);

  always_comb begin
    strobe.alloc = (dispValid && !wawHaz) ? target : '0;
    strobe.issue = pick;
    strobe.wb    = wbOh;
  end

endmodule

// File: rtl/scoreboard_issue.sv
module scoreboard_issue import sb_pkg::*; #(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      dispValid,
  input  logic [1:0]                dispClass,
  input  logic                      dispWrites,
  input  logic [REG_W-1:0]          dispDst,
  input  logic [REG_W-1:0]          dispSrcA,
  input  logic [REG_W-1:0]          dispSrcB,
  input  logic [FU_COUNT-1:0]       unitDone,
  output logic                      dispStall,
  output logic [FU_COUNT-1:0]       issueGrant,
  output logic [REG_W-1:0]          issueSrcA,
  output logic [REG_W-1:0]          issueSrcB,
  output logic [FU_COUNT-1:0]       rfWe,
  output logic [FU_COUNT*REG_W-1:0] rfWaddr
);

  strobe_t                           strobe;
  logic [FU_COUNT-1:0]               busy, issued, execDone, writes;
  logic [FU_COUNT-1:0][REG_W-1:0]    dst, srcA, srcB;
  logic [FU_COUNT-1:0][TAG_W-1:0]    tagA, tagB;
  logic [FU_COUNT-1:0][FU_COUNT-1:0] older;
  logic [TAG_W-1:0]                  pendTag;

  sb_tables #(.NUM_REGS(NUM_REGS)) tables_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dispWrites(dispWrites), .dispDst(dispDst),
    .dispSrcA(dispSrcA), .dispSrcB(dispSrcB), .unitDone(unitDone),
    .busy(busy), .issued(issued), .execDone(execDone), .writes(writes),
    .dst(dst), .srcA(srcA), .srcB(srcB), .tagA(tagA), .tagB(tagB),
    .older(older), .pendTag(pendTag)
  );

  sb_ctrl #(.REG_W(REG_W)) ctrl_i (
    .dispValid(dispValid), .dispClass(dispClass), .dispWrites(dispWrites),
    .pendTag(pendTag), .busy(busy), .issued(issued), .execDone(execDone),
    .writes(writes), .dst(dst), .srcA(srcA), .srcB(srcB),
    .tagA(tagA), .tagB(tagB), .older(older),
    .strobe(strobe), .dispStall(dispStall)
  );

  assign issueGrant = strobe.issue;
  assign rfWe       = strobe.wb & writes;

  always_comb begin
    issueSrcA = '0;
    issueSrcB = '0;
    for (int u = 0; u < FU_COUNT; u++)
      if (strobe.issue[u]) begin
        issueSrcA = srcA[u];
        issueSrcB = srcB[u];
      end
  end

  for (genvar u = 0; u < FU_COUNT; u++) begin : g_waddr
    assign rfWaddr[u*REG_W +: REG_W] = dst[u];
  end

endmodule

// File: rtl/sb_checker.sv
module sb_checker import sb_pkg::*; #(
  parameter int REG_W = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      dispValid,
  input logic                      dispStall,
  input logic [FU_COUNT-1:0]       issueGrant,
  input logic [FU_COUNT-1:0]       rfWe,
  input logic [FU_COUNT*REG_W-1:0] rfWaddr
);

  logic dupWrite;

  always_comb begin
    dupWrite = 1'b0;
    for (int i = 0; i < FU_COUNT; i++)
      for (int j = i + 1; j < FU_COUNT; j++)
        if (rfWe[i] && rfWe[j] &&
            rfWaddr[i*REG_W +: REG_W] == rfWaddr[j*REG_W +: REG_W])
          dupWrite = 1'b1;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (issueGrant == '0 && rfWe == '0));

  p_stall_needs_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    dispStall |-> dispValid);

  p_single_writer_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dupWrite);

  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issueGrant));

  p_no_write_while_granted_r8: assert property (@(posedge clk) disable iff (!rstN)
    (issueGrant & rfWe) == '0);

  p_no_back_to_back_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe & $past(rfWe)) == '0);

endmodule

bind scoreboard_issue sb_checker #(.REG_W(REG_W)) chk_i (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispStall(dispStall),
  .issueGrant(issueGrant), .rfWe(rfWe), .rfWaddr(rfWaddr)
);

// File: tb/scoreboard_issue_tb_top.sv
module scoreboard_issue_tb_top;

  localparam int NU = 5;
  localparam int NR = 16;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          dispValid = 1'b0;
  logic [1:0]    dispClass = '0;
  logic          dispWrites = 1'b0;
  logic [RW-1:0] dispDst = '0, dispSrcA = '0, dispSrcB = '0;
  logic [NU-1:0] unitDone = '0;
  logic          dispStall;
  logic [NU-1:0] issueGrant, rfWe;
  logic [RW-1:0] issueSrcA, issueSrcB;
  logic [NU*RW-1:0] rfWaddr;

  scoreboard_issue #(.NUM_REGS(NR)) dut_i (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispClass(dispClass),
    .dispWrites(dispWrites), .dispDst(dispDst), .dispSrcA(dispSrcA),
    .dispSrcB(dispSrcB), .unitDone(unitDone), .dispStall(dispStall),
    .issueGrant(issueGrant), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .rfWe(rfWe), .rfWaddr(rfWaddr)
  );

  always #5 clk = ~clk;

  typedef struct { int cls; int wr; int d; int a; int b; } ins_t;
  ins_t q[$];

  int nCmp = 0, nBad = 0, cycles = 0;
  bit finished = 0;
  bit spurious = 0;
  bit idleGaps = 0;

  // behavioural model state
  int mBusy[NU], mIss[NU], mXd[NU], mWr[NU], mDst[NU], mSa[NU], mSb[NU];
  int mTa[NU], mTb[NU], mSeq[NU], mCnt[NU];
  int mReg[NR];
  int seqCtr = 0;
  int lat[NU] = '{1, 2, 1, 3, 3};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  // evaluate one cycle: compare outputs, then advance the model
  task automatic stepModel(output bit accepted);
    int wb[NU], effA[NU], effB[NU], regEff[NR], freeU[NU], doneOk[NU];
    int pick, tgt, haz, stl, expGrant, expWe, war, cls, u;
    for (int i = 0; i < NU; i++) begin
      war = 0;
      if (mWr[i] != 0)
        for (int v = 0; v < NU; v++)
          if (v != i && mBusy[v] != 0 && mIss[v] == 0 &&
              ((mSa[v] == mDst[i] && mTa[v] == 0) || (mSb[v] == mDst[i] && mTb[v] == 0)))
            war = 1;
      wb[i] = (mBusy[i] != 0 && mXd[i] != 0 && war == 0) ? 1 : 0;
    end
    for (int i = 0; i < NU; i++) begin
      effA[i] = (mTa[i] != 0 && wb[mTa[i]-1] != 0) ? 0 : mTa[i];
      effB[i] = (mTb[i] != 0 && wb[mTb[i]-1] != 0) ? 0 : mTb[i];
      freeU[i] = (mBusy[i] == 0 || wb[i] != 0) ? 1 : 0;
    end
    for (int r = 0; r < NR; r++)
      regEff[r] = (mReg[r] != 0 && wb[mReg[r]-1] != 0) ? 0 : mReg[r];
    pick = -1;
    for (int i = 0; i < NU; i++)
      if (mBusy[i] != 0 && mIss[i] == 0 && effA[i] == 0 && effB[i] == 0)
        if (pick < 0 || mSeq[i] < mSeq[pick]) pick = i;
    tgt = -1;
    cls = int'(dispClass);
    if (cls < 3) begin
      if (freeU[cls] != 0) tgt = cls;
    end else begin
      for (int i = 3; i < NU; i++) if (freeU[i] != 0 && tgt < 0) tgt = i;
    end
    haz = (dispValid && dispWrites && regEff[int'(dispDst)] != 0) ? 1 : 0;
    stl = (dispValid && (tgt < 0 || haz != 0)) ? 1 : 0;
    expGrant = (pick >= 0) ? (1 << pick) : 0;
    expWe = 0;
    for (int i = 0; i < NU; i++) if (wb[i] != 0 && mWr[i] != 0) expWe |= (1 << i);

    check(int'(dispStall) == stl, "R3 R4 R5", "dispStall", int'(dispStall), stl);
    check(int'(issueGrant) == expGrant, "R2 R6 R7", "issueGrant", int'(issueGrant), expGrant);
    if (pick >= 0) begin
      check(int'(issueSrcA) == mSa[pick], "R7", "issueSrcA", int'(issueSrcA), mSa[pick]);
      check(int'(issueSrcB) == mSb[pick], "R7", "issueSrcB", int'(issueSrcB), mSb[pick]);
    end
    check(int'(rfWe) == expWe, "R8 R9 R10 R11", "rfWe", int'(rfWe), expWe);
    for (int i = 0; i < NU; i++)
      if (((expWe >> i) & 1) != 0)
        check(int'(rfWaddr[i*RW +: RW]) == mDst[i], "R8", "rfWaddr", int'(rfWaddr[i*RW +: RW]), mDst[i]);

    // next state
    for (int i = 0; i < NU; i++)
      doneOk[i] = (unitDone[i] && mBusy[i] != 0 && mIss[i] != 0) ? 1 : 0;
    for (int i = 0; i < NU; i++) begin
      if (wb[i] != 0) mBusy[i] = 0;
      if (doneOk[i] != 0) mXd[i] = 1;
      mTa[i] = effA[i];
      mTb[i] = effB[i];
    end
    if (pick >= 0) begin
      mIss[pick] = 1;
      mCnt[pick] = lat[pick];
    end
    for (int r = 0; r < NR; r++) mReg[r] = regEff[r];
    accepted = (dispValid && stl == 0);
    if (accepted) begin
      u = tgt;
      mBusy[u] = 1; mIss[u] = 0; mXd[u] = 0;
      mWr[u] = int'(dispWrites);
      mDst[u] = int'(dispDst); mSa[u] = int'(dispSrcA); mSb[u] = int'(dispSrcB);
      mTa[u] = regEff[mSa[u]]; mTb[u] = regEff[mSb[u]];
      mSeq[u] = seqCtr++;
      mCnt[u] = 0;
      if (mWr[u] != 0) mReg[mDst[u]] = u + 1;
    end
  endtask

  task automatic oneCycle();
    bit acc;
    int su;
    @(negedge clk);
    cycles++;
    for (int i = 0; i < NU; i++) begin
      unitDone[i] = 1'b0;
      if (mCnt[i] > 0) begin
        mCnt[i]--;
        if (mCnt[i] == 0) unitDone[i] = 1'b1;
      end
    end
    if (spurious && ($urandom % 4) == 0) begin
      su = int'($urandom % NU);
      if (!(mBusy[su] != 0 && mIss[su] != 0)) unitDone[su] = 1'b1; // R10 stray pulse
    end
    if (q.size() > 0 && !(idleGaps && ($urandom % 4) == 0)) begin
      dispValid  = 1'b1;
      dispClass  = 2'(q[0].cls);
      dispWrites = q[0].wr != 0;
      dispDst    = RW'(q[0].d);
      dispSrcA   = RW'(q[0].a);
      dispSrcB   = RW'(q[0].b);
    end else begin
      dispValid = 1'b0;
    end
    #1;
    stepModel(acc);
    if (acc) void'(q.pop_front());
  endtask

  function automatic ins_t mk(int cls, int wr, int d, int a, int b);
    ins_t t;
    t.cls = cls; t.wr = wr; t.d = d; t.a = a; t.b = b;
    return t;
  endfunction

  task automatic drain();
    int busyAny;
    do begin
      oneCycle();
      busyAny = 0;
      for (int i = 0; i < NU; i++) busyAny |= mBusy[i];
    end while (q.size() > 0 || busyAny != 0);
    repeat (2) oneCycle();
  endtask

  initial begin
    for (int i = 0; i < NU; i++) begin
      mBusy[i] = 0; mIss[i] = 0; mXd[i] = 0; mWr[i] = 0; mDst[i] = 0;
      mSa[i] = 0; mSb[i] = 0; mTa[i] = 0; mTb[i] = 0; mSeq[i] = 0; mCnt[i] = 0;
    end
    for (int r = 0; r < NR; r++) mReg[r] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1: quiet reset state
    check(dispStall == 1'b0, "R1", "dispStall", int'(dispStall), 0);
    check(issueGrant == '0, "R1", "issueGrant", int'(issueGrant), 0);
    check(rfWe == '0, "R1", "rfWe", int'(rfWe), 0);

    // loop of load, multiply, store, increment twice: R2 R4 R6 R8 R9
    q.push_back(mk(1, 1, 1, 5, 5));
    q.push_back(mk(3, 1, 2, 0, 1));
    q.push_back(mk(2, 0, 0, 2, 5));
    q.push_back(mk(0, 1, 5, 5, 5));
    q.push_back(mk(1, 1, 1, 5, 5));
    q.push_back(mk(3, 1, 2, 0, 1));
    q.push_back(mk(2, 0, 0, 2, 5));
    drain();

    // three independent FP ops: R2 lowest free, R3 structural, R5 free-then-allocate
    q.push_back(mk(3, 1, 6, 0, 0));
    q.push_back(mk(3, 1, 7, 0, 0));
    q.push_back(mk(3, 1, 8, 0, 0));
    drain();

    // WAW across classes: R4
    q.push_back(mk(1, 1, 9, 3, 3));
    q.push_back(mk(3, 1, 9, 4, 4));
    drain();

    // one producer, two consumers of different age: R6 R7
    q.push_back(mk(3, 1, 10, 11, 11));
    q.push_back(mk(0, 1, 12, 10, 3));
    q.push_back(mk(1, 1, 13, 10, 4));
    drain();

    // random stream: R5 R9 R10 R11 mixed
    spurious = 1;
    idleGaps = 1;
    for (int n = 0; n < 3000; n++) begin
      int c = int'($urandom % 4);
      q.push_back(mk(c, (c == 2) ? 0 : 1, int'($urandom % 8),
                     int'($urandom % 8), int'($urandom % 8)));
    end
    drain();
    finishRun();
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: run did not complete, actual %0d cycles expected fewer", cycles);
    finishRun();
  end

endmodule